// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

The block arbitrates eight interrupt request lines for a processor. Software brings it up with a short sequence of initialization bytes written over a byte-wide register interface with a single address bit. The first byte of the sequence is written at address 0 and carries a marker bit. The following bytes, at address 1, set the vector base and optional cascade and mode bytes. After that, address 1 holds the mask register, and address 0 takes command bytes: end-of-interrupt commands and a read-select byte that decides whether an address 0 read returns the request register or the in-service register.

Each input is set to edge or level trigger through a separate trigger register. The interrupt output is raised while any request is pending and not masked. Input 0 has the highest priority. The vector is the programmed base plus the index of the winning input. The processor pulses the acknowledge input to accept that vector. The acknowledge marks the input as in service, and for an edge input it also consumes the request. Unsupported command codes raise a one-cycle error flag.

Top module: `irq_ctl8`

## Requirements
- R1: A write to address 0 with bit 4 set restarts initialization from any state: the byte is kept as the setup byte, and the next address 1 write is taken as the vector base, not as a mask.
- R2: After the vector base, the next step depends on the setup byte. If setup bit 1 (single) is 0, the next address 1 write is the cascade byte. Otherwise, if setup bit 0 (fourth-byte request) is 1, the next address 1 write is the mode byte. Otherwise the block is ready. After the cascade byte, the next step is the mode byte if setup bit 0 is 1, and ready if it is not. Mode and cascade writes do not change the mask.
- R3: When ready, an address 1 write loads the mask register, and an address 1 read always returns the mask.
- R4: A write to address 0 with bit 4 = 0 and bit 3 = 1 is a read-select byte. An address 0 read returns the request register when its bits [1:0] are 2'b10, the in-service register when they are 2'b11, and 0x00 for any other value.
- R5: `int_o` is high exactly when (request & ~mask) is nonzero.
- R6: `vec_o` is the vector base plus the index of the lowest-numbered set bit of (request & ~mask). An acknowledge sets that bit in the in-service register.
- R7: For an input whose trigger bit is 0 (edge), the request bit is set on a rising edge of the line and cleared by the acknowledge of that input. For an input whose trigger bit is 1 (level), the request bit follows the line and an acknowledge leaves it set.
- R8: An acknowledge while `int_o` is low changes no state.
- R9: A write to address 0 with bits 4 and 3 both 0 is an end-of-interrupt command, with bits [7:5] holding {rotate, select, eoi}. Code 3'b001 clears the lowest-numbered set in-service bit. Code 3'b011 clears the in-service bit named by bits [2:0].
- R10: Command codes 3'b110 and 3'b010 are accepted and have no effect. Every other code with eoi-or-select semantics not listed in R9 (3'b000, 3'b100, 3'b101, 3'b111) raises `cmd_err_o` for exactly one cycle after the write and changes no state.
- R11: A `trig_wr_i` pulse loads `wdata_i` into the trigger register, which `trig_o` shows.
- R12: After reset, the request, in-service, mask and trigger registers are 0x00, `int_o` is low, and the block waits for a setup byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Write data, shared by register and trigger writes |
| rdata_o | output | 8 | Read data for `addr_i` |
| trig_wr_i | input | 1 | Trigger register write strobe |
| trig_o | output | 8 | Trigger register contents (1 = level) |
| req_i | input | 8 | Interrupt request lines |
| int_o | output | 1 | Interrupt output to the processor |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| vec_o | output | 8 | Vector of the winning request |
| cmd_err_o | output | 1 | Unsupported command flag, one cycle |

## Verification
The hardest state to reach is a level input that has been acknowledged while its line is still high. In that state the input is in service and its request bit is still set, so the input keeps winning arbitration after the acknowledge. The stimulus sets the trigger bit first, raises the line, acknowledges, and then reads both registers through the read-select byte before it drops the line. The same sequence, with the input masked, is used to issue an acknowledge while `int_o` is low and then read back the in-service register to show it is unchanged.

// File: rtl/irq_ctl8_pkg.sv
package irq_ctl8_pkg;

    parameter int unsigned NUM_IN = 8;
    parameter int unsigned BUS_W  = 8;
    localparam int unsigned IDX_W = $clog2(NUM_IN);

    // bit positions decoded from address 0 writes
    localparam int unsigned SETUP_MARK_BIT = 4;
    localparam int unsigned RDSEL_MARK_BIT = 3;
    localparam int unsigned SINGLE_BIT     = 1;
    localparam int unsigned MODE_REQ_BIT   = 0;

    typedef enum logic [2:0] {
        WAIT_SETUP = 3'd1,
        WAIT_BASE  = 3'd2,
        WAIT_CASC  = 3'd3,
        WAIT_MODE  = 3'd4,
        RUN        = 3'd5
    } init_st_e;

    typedef struct packed {
        logic [BUS_W-1:0]  isr;
        logic [BUS_W-1:0]  imr;
        logic [BUS_W-1:0]  trig;
        logic [BUS_W-1:0]  setup;
        logic [BUS_W-1:0]  base;
        logic [BUS_W-1:0]  casc;
        logic [BUS_W-1:0]  mode;
        logic [BUS_W-1:0]  rdsel;
        init_st_e          st;
        logic              err;
    } ctl_regs_t;

endpackage

// File: rtl/irq_ctl8_prio.sv
module irq_ctl8_prio #(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned IW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             any_o,
    output logic [IW-1:0]    idx_o,
    output logic [WIDTH-1:0] onehot_o
);

    // lowest index wins
    always_comb begin
        any_o    = |vec_i;
        onehot_o = vec_i & (~vec_i + WIDTH'(1));
        idx_o    = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_ctl8_reqlat.sv
module irq_ctl8_reqlat #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] line_i,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] ack_clr_i,
    output logic [WIDTH-1:0] irr_o
);

    logic [WIDTH-1:0] irr_d, irr_q;
    logic [WIDTH-1:0] prev_d, prev_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            if (level_i[b]) begin
                irr_d[b] = line_i[b];
            end else begin
                irr_d[b] = (irr_q[b] & ~ack_clr_i[b]) | (line_i[b] & ~prev_q[b]);
            end
        end
    end

    always_comb prev_d = line_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irr_q  <= '0;
            prev_q <= '0;
        end else begin
            irr_q  <= irr_d;
            prev_q <= prev_d;
        end
    end

    assign irr_o = irr_q;

endmodule

// File: rtl/irq_ctl8.sv
module irq_ctl8
    import irq_ctl8_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    input  logic              trig_wr_i,
    output logic [BUS_W-1:0]  trig_o,
    input  logic [NUM_IN-1:0] req_i,
    output logic              int_o,
    input  logic              ack_i,
    output logic [BUS_W-1:0]  vec_o,
    output logic              cmd_err_o
);

    localparam ctl_regs_t CTL_RST = '{st: WAIT_SETUP, default: '0};

    ctl_regs_t r_d, r_q;

    logic [NUM_IN-1:0] irr;
    logic [NUM_IN-1:0] pend;
    logic              win_any;
    logic [IDX_W-1:0]  win_idx;
    logic [NUM_IN-1:0] win_oh;
    logic              isr_any;
    logic [IDX_W-1:0]  isr_idx;
    logic [NUM_IN-1:0] isr_oh;
    logic [NUM_IN-1:0] ack_set;
    logic [NUM_IN-1:0] ack_clr;
    logic [NUM_IN-1:0] eoi_clr;

    assign pend = irr & ~r_q.imr[NUM_IN-1:0];

    irq_ctl8_prio #(.WIDTH(NUM_IN)) u_win (
        .vec_i    (pend),
        .any_o    (win_any),
        .idx_o    (win_idx),
        .onehot_o (win_oh)
    );

    irq_ctl8_prio #(.WIDTH(NUM_IN)) u_isr (
        .vec_i    (r_q.isr[NUM_IN-1:0]),
        .any_o    (isr_any),
        .idx_o    (isr_idx),
        .onehot_o (isr_oh)
    );

    assign ack_set = (ack_i && win_any) ? win_oh : '0;
    assign ack_clr = ack_set & ~r_q.trig[NUM_IN-1:0];

    irq_ctl8_reqlat #(.WIDTH(NUM_IN)) u_req (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .line_i    (req_i),
        .level_i   (r_q.trig[NUM_IN-1:0]),
        .ack_clr_i (ack_clr),
        .irr_o     (irr)
    );

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        eoi_clr = '0;

        if (trig_wr_i) begin
            r_d.trig = wdata_i;
        end

        if (wr_en_i && !addr_i) begin
            if (wdata_i[SETUP_MARK_BIT]) begin
                r_d.setup = wdata_i;
                r_d.st    = WAIT_BASE;
            end else if (wdata_i[RDSEL_MARK_BIT]) begin
                r_d.rdsel = wdata_i;
            end else begin
                unique case (wdata_i[7:5])
                    3'b001: eoi_clr = isr_any ? isr_oh : '0;
                    3'b011: eoi_clr[wdata_i[IDX_W-1:0]] = 1'b1;
                    3'b110, 3'b010: ;
                    default: r_d.err = 1'b1;
                endcase
            end
        end

        if (wr_en_i && addr_i) begin
            unique case (r_q.st)
                WAIT_BASE: begin
                    r_d.base = wdata_i;
                    if (!r_q.setup[SINGLE_BIT]) begin
                        r_d.st = WAIT_CASC;
                    end else if (r_q.setup[MODE_REQ_BIT]) begin
                        r_d.st = WAIT_MODE;
                    end else begin
                        r_d.st = RUN;
                    end
                end
                WAIT_CASC: begin
                    r_d.casc = wdata_i;
                    r_d.st   = r_q.setup[MODE_REQ_BIT] ? WAIT_MODE : RUN;
                end
                WAIT_MODE: begin
                    r_d.mode = wdata_i;
                    r_d.st   = RUN;
                end
                RUN:     r_d.imr = wdata_i;
                default: ;
            endcase
        end

        r_d.isr[NUM_IN-1:0] = (r_q.isr[NUM_IN-1:0] | ack_set) & ~eoi_clr;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= CTL_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (addr_i) begin
            rdata_o = r_q.imr;
        end else begin
            unique case (r_q.rdsel[1:0])
                2'b10:   rdata_o = BUS_W'(irr);
                2'b11:   rdata_o = r_q.isr;
                default: rdata_o = '0;
            endcase
        end
    end

    assign int_o     = win_any;
    assign vec_o     = r_q.base + BUS_W'(win_idx);
    assign trig_o    = r_q.trig;
    assign cmd_err_o = r_q.err;

endmodule

// File: rtl/irq_ctl8_chk.sv
module irq_ctl8_chk
    import irq_ctl8_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic              addr_i,
    input logic [BUS_W-1:0]  wdata_i,
    input logic              ack_i,
    input logic              int_o,
    input logic              cmd_err_o,
    input logic [BUS_W-1:0]  isr_q,
    input logic [BUS_W-1:0]  imr_q,
    input init_st_e          st_q,
    input logic [NUM_IN-1:0] win_oh
);

    p_setup_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !addr_i && wdata_i[SETUP_MARK_BIT]) |=> (st_q == WAIT_BASE));

    p_mask_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i && st_q == RUN) |=> (imr_q == $past(wdata_i)));

    p_ack_sets_isr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && int_o && !wr_en_i) |=> ((isr_q[NUM_IN-1:0] & $past(win_oh)) != '0));

    p_ack_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !int_o && !wr_en_i) |=> $stable(isr_q));

    p_specific_eoi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !addr_i && wdata_i[7:3] == 5'b01100 && !ack_i)
        |=> (isr_q[$past(wdata_i[IDX_W-1:0])] == 1'b0));

    p_err_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_err_o |-> $past(wr_en_i && !addr_i));

endmodule

bind irq_ctl8 irq_ctl8_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .ack_i     (ack_i),
    .int_o     (int_o),
    .cmd_err_o (cmd_err_o),
    .isr_q     (r_q.isr),
    .imr_q     (r_q.imr),
    .st_q      (r_q.st),
    .win_oh    (win_oh)
);

// File: tb/irq_ctl8_bench.sv
module irq_ctl8_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       trig_wr = 1'b0;
    logic [7:0] trig;
    logic [7:0] req = 8'h00;
    logic       intr;
    logic       ack = 1'b0;
    logic [7:0] vec;
    logic       cerr;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    irq_ctl8 u_irq_ctl8 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .trig_wr_i (trig_wr),
        .trig_o    (trig),
        .req_i     (req),
        .int_o     (intr),
        .ack_i     (ack),
        .vec_o     (vec),
        .cmd_err_o (cerr)
    );

    // behavioural reference model
    logic [7:0] m_irr, m_isr, m_imr, m_trig, m_setup, m_base, m_rdsel, m_prev;
    logic [7:0] m_pend, m_nirr, m_setb, m_clrb;
    logic       m_err;
    int         m_st, m_w, m_e;

    function automatic int lowest(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_irr = 0; m_isr = 0; m_imr = 0; m_trig = 0; m_setup = 0;
            m_base = 0; m_rdsel = 0; m_prev = 0; m_err = 0; m_st = 1;
        end else begin
            m_pend = m_irr & ~m_imr;
            m_w = lowest(m_pend);
            m_setb = 0;
            m_clrb = 0;
            if (ack && m_w >= 0) m_setb[m_w] = 1'b1;
            for (int i = 0; i < 8; i++) begin
                if (m_trig[i]) m_nirr[i] = req[i];
                else m_nirr[i] = (m_irr[i] && !m_setb[i]) || (req[i] && !m_prev[i]);
            end
            m_err = 1'b0;
            if (wr_en && !addr) begin
                if (wdata[4]) begin
                    m_setup = wdata;
                    m_st = 2;
                end else if (wdata[3]) begin
                    m_rdsel = wdata;
                end else if (wdata[7:5] == 3'b001) begin
                    m_e = lowest(m_isr);
                    if (m_e >= 0) m_clrb[m_e] = 1'b1;
                end else if (wdata[7:5] == 3'b011) begin
                    m_clrb[wdata[2:0]] = 1'b1;
                end else if (wdata[7:5] != 3'b110 && wdata[7:5] != 3'b010) begin
                    m_err = 1'b1;
                end
            end
            if (wr_en && addr) begin
                case (m_st)
                    2: begin
                        m_base = wdata;
                        m_st = !m_setup[1] ? 3 : (m_setup[0] ? 4 : 5);
                    end
                    3: m_st = m_setup[0] ? 4 : 5;
                    4: m_st = 5;
                    5: m_imr = wdata;
                    default: ;
                endcase
            end
            m_isr = (m_isr | m_setb) & ~m_clrb;
            m_irr = m_nirr;
            m_prev = req;
            if (trig_wr) m_trig = wdata;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            #2;
            chk("R5", {7'd0, intr}, {7'd0, (m_irr & ~m_imr) != 0});
            if ((m_irr & ~m_imr) != 0)
                chk("R6", vec, m_base + 8'(lowest(m_irr & ~m_imr)));
            if (addr) chk("R3", rdata, m_imr);
            else chk("R4", rdata, (m_rdsel[1:0] == 2'b10) ? m_irr :
                                  (m_rdsel[1:0] == 2'b11) ? m_isr : 8'h00);
            chk("R11", trig, m_trig);
            chk("R10", {7'd0, cerr}, {7'd0, m_err});
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(logic a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic trigw(logic [7:0] d);
        wdata = d; trig_wr = 1'b1;
        tick();
        trig_wr = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    task automatic rd(logic a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    logic [7:0] v;

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R12 reset state
        rd(0, v); chk("R12", v, 8'h00);
        rd(1, v); chk("R12", v, 8'h00);
        chk("R12", {7'd0, intr}, 8'h00);
        chk("R12", trig, 8'h00);

        // R2: single, no mode byte -> ready after base
        wr(0, 8'h12); wr(1, 8'h30); wr(1, 8'hA5);
        rd(1, v); chk("R2", v, 8'hA5);
        // R2: single with mode byte
        wr(0, 8'h13); wr(1, 8'h30); wr(1, 8'h77);
        rd(1, v); chk("R2", v, 8'hA5);
        wr(1, 8'h5A);
        rd(1, v); chk("R2", v, 8'h5A);
        // R2: cascade then mode byte
        wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h04);
        rd(1, v); chk("R2", v, 8'h5A);
        wr(1, 8'h01); wr(1, 8'h00);
        rd(1, v); chk("R3", v, 8'h00);

        // R7 edge capture, R6 vector
        wr(0, 8'h0A);
        req = 8'h24; tick();
        rd(0, v); chk("R7", v, 8'h24);
        chk("R5", {7'd0, intr}, 8'h01);
        chk("R6", vec, 8'h42);
        pulse_ack();
        rd(0, v); chk("R7", v, 8'h20);
        chk("R6", vec, 8'h45);
        wr(0, 8'h0B);
        rd(0, v); chk("R4", v, 8'h04);
        pulse_ack();
        rd(0, v); chk("R6", v, 8'h24);
        chk("R5", {7'd0, intr}, 8'h00);
        // R8 acknowledge with nothing pending
        pulse_ack();
        rd(0, v); chk("R8", v, 8'h24);
        // R9 end of interrupt
        wr(0, 8'h20);
        rd(0, v); chk("R9", v, 8'h20);
        wr(0, 8'h65);
        rd(0, v); chk("R9", v, 8'h00);

        // R7 level input keeps its request through acknowledge
        trigw(8'h08);
        chk("R11", trig, 8'h08);
        req = 8'h2C; tick();
        wr(0, 8'h0A);
        rd(0, v); chk("R7", v, 8'h08);
        chk("R6", vec, 8'h43);
        pulse_ack();
        rd(0, v); chk("R7", v, 8'h08);
        wr(0, 8'h0B);
        rd(0, v); chk("R6", v, 8'h08);
        req = 8'h24; tick();
        wr(0, 8'h0A);
        rd(0, v); chk("R7", v, 8'h00);

        // R5 masking, R8 ignored acknowledge
        req = 8'h26; tick();
        wr(1, 8'h02);
        chk("R5", {7'd0, intr}, 8'h00);
        pulse_ack();
        wr(0, 8'h0B);
        rd(0, v); chk("R8", v, 8'h08);
        wr(1, 8'h00);
        chk("R5", {7'd0, intr}, 8'h01);
        chk("R6", vec, 8'h41);

        // R10 accepted no-ops and rejected codes
        wr(0, 8'hC0); chk("R10", {7'd0, cerr}, 8'h00);
        wr(0, 8'h40); chk("R10", {7'd0, cerr}, 8'h00);
        wr(0, 8'hA0); chk("R10", {7'd0, cerr}, 8'h01);
        tick();       chk("R10", {7'd0, cerr}, 8'h00);
        rd(0, v); chk("R10", v, 8'h08);

        // R4 read select with other low bits
        wr(0, 8'h08);
        rd(0, v); chk("R4", v, 8'h00);

        // R11 trigger register
        trigw(8'h5C);
        chk("R11", trig, 8'h5C);

        // R1 restart in the ready state, new base
        wr(0, 8'h13); wr(1, 8'h48);
        chk("R1", vec, 8'h49);
        rd(1, v); chk("R1", v, 8'h00);
        wr(1, 8'h00);
        repeat (2) tick();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule